// File: doc/BRIEF.md
# Keyed Watchdog Timer with Reset Pulse Output

This block guards a processor against runaway software. It counts machine cycles once software has armed it, and it raises a reset pulse of fixed length unless software refreshes it in time. The only software interface is a single write-only byte register. Writing the opening key 8'h1E followed directly by the closing key 8'hE1 turns the watchdog on the first time. Every later pair of the same kind clears the count. Neither the count nor the on/off state can be read, and nothing short of a reset turns the watchdog off.

When the count reaches its top value, the block raises an internal reset request for a fixed number of clock periods. The same pulse is also driven onto an external reset output unless a configuration bit masks it. Low-power states are taken into account. In idle, a configuration bit chooses whether counting continues or freezes. In power-down the count is frozen. After a wake-up from power-down by an external interrupt, counting stays held until the interrupt pin goes back high. When the reset pulse ends, the block is disarmed again and its count is cleared.

Top module: `keyed_wdog`

## Requirements
- R1: While `rst_n` is low and after it rises, the watchdog is disarmed, and `rst_req` and `rst_out` are both 0.
- R2: A write of 8'h1E followed by a write of 8'hE1 as the very next write arms the watchdog. The count is 0 after the closing write and advances by one on each later clock where `cyc_tick` is 1.
- R3: The key pair is accepted only when the two writes are back to back. Any other value written after 8'h1E, including a second 8'h1E, cancels the opening key. A lone 8'hE1 does nothing.
- R4: While armed, a complete key pair resets the count to 0. No write of any value disarms the watchdog.
- R5: The overflow happens on the clock edge where the count reaches 2^CNT_W-1, which is 16383 for the default width. From the next cycle, `rst_req` stays at 1 for exactly PULSE_LEN clock cycles (default 98).
- R6: `rst_out` follows `rst_req` when `cfg_rst_out_dis` is 0. When `cfg_rst_out_dis` is 1, `rst_out` stays 0 while `rst_req` still pulses.
- R7: With `idle` at 1 and `cfg_idle_halt` at 1, the count holds its value and resumes from it when idle ends. With `cfg_idle_halt` at 0, counting continues during idle.
- R8: The count does not advance while `pdown` is 1. After power-down ends with `wake_pin` at 0, the count stays frozen until `wake_pin` is 1.
- R9: When the reset pulse ends, the watchdog is disarmed with the count at 0. Cycle ticks then cause no further overflow until it is armed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| wr_en | input | 1 | Write strobe for the watchdog key register |
| wr_data | input | 8 | Byte written to the key register |
| cyc_tick | input | 1 | One-clock strobe per machine cycle |
| idle | input | 1 | Processor is in idle mode |
| pdown | input | 1 | Processor is in power-down mode |
| wake_pin | input | 1 | Level of the external interrupt pin used for wake-up (low = asserted) |
| cfg_rst_out_dis | input | 1 | 1 masks the reset pulse on `rst_out` |
| cfg_idle_halt | input | 1 | 1 freezes counting during idle |
| rst_out | output | 1 | Reset pulse driven to the reset pin |
| rst_req | output | 1 | Internal reset request, high for the pulse length |

## Verification
The hardest state to reach from the ports is the window after power-down has ended while the wake-up pin is still held low. In that window the count must stay frozen even though ticks arrive and no low-power input is active. The stimulus arms the watchdog and spends a known number of ticks. It then holds the pin low through power-down and beyond its end, releases the pin, and checks that the overflow comes exactly after the remaining tick count. Because the count is hidden, every freeze and every clear is measured the same way, as the exact edge on which the reset pulse starts.

// File: rtl/kwd_pkg.sv
// Shared types for the keyed watchdog.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package kwd_pkg;

    // Two-state key sequence tracker.
    typedef enum logic {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } key_state_e;

endpackage

// File: rtl/kwd_key_detect.sv
// Key sequence detector: raises key_ok combinationally on the write that
// completes KEY_A followed directly by KEY_B.
// Assumes: wr_en is a one-clock strobe addressed only to the key register;
// clr is a synchronous clear coming from the watchdog reset pulse.
module kwd_key_detect
    import kwd_pkg::*;
#(
    parameter int          DATA_W = 8,
    parameter logic [7:0]  KEY_A  = 8'h1E,
    parameter logic [7:0]  KEY_B  = 8'hE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              key_ok
);

    localparam logic [DATA_W-1:0] OPEN_KEY  = DATA_W'(KEY_A);
    localparam logic [DATA_W-1:0] CLOSE_KEY = DATA_W'(KEY_B);

    key_state_e state_q, state_d;

    // Next-state and completion decode for the key sequence.
    always_comb begin
        state_d = state_q;
        key_ok  = 1'b0;
        if (wr_en) begin
            unique case (state_q)
                KEY_IDLE:  state_d = (wr_data == OPEN_KEY) ? KEY_ARMED : KEY_IDLE;
                KEY_ARMED: begin
                    key_ok  = (wr_data == CLOSE_KEY);
                    state_d = KEY_IDLE;
                end
                default:   state_d = KEY_IDLE;
            endcase
        end
    end

    // State register, cleared by hardware reset and by the watchdog pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) state_q <= KEY_IDLE;
        else               state_q <= state_d;
    end

    // R3: the armed state is entered only right after an opening-key write.
    a_r3_armed_after_open: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == KEY_ARMED && $past(state_q) == KEY_IDLE)
            |-> $past(wr_en && wr_data == OPEN_KEY));

    // R3: any write seen in the armed state leaves it.
    a_r3_single_chance: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == KEY_ARMED && wr_en) |=> (state_q == KEY_IDLE));

endmodule

// File: rtl/kwd_counter.sv
// Watchdog count: arms on the first key, clears on later keys, advances on
// machine-cycle ticks subject to idle and power-down gating, and flags the
// edge where the count reaches its top value.
// Assumes: clr is held for the whole reset pulse; wake_pin low = asserted.
module kwd_counter #(
    parameter int CNT_W = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic key_ok,
    input  logic tick,
    input  logic idle,
    input  logic idle_halt,
    input  logic pdown,
    input  logic wake_pin,
    output logic ovf
);

    localparam logic [CNT_W-1:0] TOP_VAL  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] LAST_VAL = TOP_VAL - 1'b1;

    logic             enabled_q;
    logic [CNT_W-1:0] count_q;
    logic             wake_hold_q;
    logic             gate_ok;
    logic             adv;

    // Tick qualification from the low-power state.
    always_comb begin
        gate_ok = !pdown
                  && !(wake_hold_q && !wake_pin)
                  && !(idle && idle_halt);
        adv     = enabled_q && tick && gate_ok && (count_q != TOP_VAL) && !key_ok;
        ovf     = adv && (count_q == LAST_VAL);
    end

    // Hold flag: set in power-down, dropped once the wake pin reads high.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  wake_hold_q <= 1'b0;
        else if (pdown)     wake_hold_q <= 1'b1;
        else if (wake_pin)  wake_hold_q <= 1'b0;
    end

    // Arm flag: set by a completed key, cleared only by a reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) enabled_q <= 1'b0;
        else if (key_ok)   enabled_q <= 1'b1;
    end

    // Count register: key clears it, qualified ticks advance it.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) count_q <= '0;
        else if (key_ok)   count_q <= '0;
        else if (adv)      count_q <= count_q + 1'b1;
    end

    // R2: arming happens only through a completed key sequence.
    a_r2_arm_by_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enabled_q) |-> $past(key_ok));

    // R4: nothing but a reset pulse disarms the watchdog.
    a_r4_no_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled_q && !clr) |=> enabled_q);

    // R7: halted idle keeps the count frozen.
    a_r7_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && idle_halt && !key_ok && !clr) |=> $stable(count_q));

    // R8: power-down keeps the count frozen.
    a_r8_pdown_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (pdown && !key_ok && !clr) |=> $stable(count_q));

    // R9: after the reset pulse the watchdog is disarmed and zeroed.
    a_r9_clean_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clr) |-> (!enabled_q && count_q == '0));

endmodule

// File: rtl/kwd_pulse.sv
// Fixed-length pulse generator: starting from an idle state, a start strobe
// produces exactly PULSE_LEN cycles of active.
// Assumes: start is ignored while a pulse is running.
module kwd_pulse #(
    parameter int PULSE_LEN = 98
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);

    localparam int            PW       = $clog2(PULSE_LEN + 1);
    localparam logic [PW-1:0] LOAD_VAL = PW'(PULSE_LEN);

    logic [PW-1:0] left_q;

    // Remaining pulse length, loaded on start and run down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                         left_q <= '0;
        else if (start && left_q == '0)     left_q <= LOAD_VAL;
        else if (left_q != '0)              left_q <= left_q - 1'b1;
    end

    // Output decode of the running pulse.
    always_comb active = (left_q != '0);

    // R5: every pulse begins at the full length.
    a_r5_full_length: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> (left_q == LOAD_VAL && $past(start)));

    // R5: the remaining length never exceeds the configured pulse.
    a_r5_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        left_q <= LOAD_VAL);

endmodule

// File: rtl/keyed_wdog.sv
// Keyed watchdog top: joins the key detector, the gated counter and the
// reset pulse generator, and masks the external reset when configured.
// Assumes: one clock domain; all inputs are synchronous to clk.
module keyed_wdog #(
    parameter int         CNT_W     = 14,
    parameter int         PULSE_LEN = 98,
    parameter logic [7:0] KEY_A     = 8'h1E,
    parameter logic [7:0] KEY_B     = 8'hE1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       cyc_tick,
    input  logic       idle,
    input  logic       pdown,
    input  logic       wake_pin,
    input  logic       cfg_rst_out_dis,
    input  logic       cfg_idle_halt,
    output logic       rst_out,
    output logic       rst_req
);

    logic key_ok;
    logic ovf;
    logic pulse_on;

    kwd_key_detect #(
        .DATA_W (8),
        .KEY_A  (KEY_A),
        .KEY_B  (KEY_B)
    ) u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (pulse_on),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .key_ok  (key_ok)
    );

    kwd_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (pulse_on),
        .key_ok    (key_ok),
        .tick      (cyc_tick),
        .idle      (idle),
        .idle_halt (cfg_idle_halt),
        .pdown     (pdown),
        .wake_pin  (wake_pin),
        .ovf       (ovf)
    );

    kwd_pulse #(
        .PULSE_LEN (PULSE_LEN)
    ) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (ovf),
        .active (pulse_on)
    );

    // Output drive: internal request always, pin only when not masked.
    always_comb begin
        rst_req = pulse_on;
        rst_out = pulse_on && !cfg_rst_out_dis;
    end

    // R1: no reset activity right after a hardware reset.
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(!rst_n) |-> (!rst_req && !rst_out));

    // R6: the pin pulse never appears without the internal request.
    a_r6_out_within_req: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out |-> rst_req);

endmodule

// File: tb/test_keyed_wdog.sv
module test_keyed_wdog;

    localparam int CW    = 10;
    localparam int MAXC  = (1 << CW) - 1;
    localparam int PLEN  = 98;
    localparam int NVEC  = 6;

    // Vector: [31:24] w0, [23:16] w1, [15:8] w2, [7:4] write count, [0] arms
    localparam logic [31:0] VEC [NVEC] = '{
        32'h1E_E1_00_21,   // R2: plain key pair arms
        32'hE1_00_00_10,   // R3: lone closing key
        32'h1E_1E_E1_30,   // R3: doubled opening key
        32'h1E_00_E1_30,   // R3: foreign byte in between
        32'h00_1E_E1_31,   // R2: junk before a good pair
        32'hE1_1E_00_20    // R3: reversed order
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       cyc_tick = 1'b0;
    logic       idle = 1'b0;
    logic       pdown = 1'b0;
    logic       wake_pin = 1'b1;
    logic       cfg_rst_out_dis = 1'b0;
    logic       cfg_idle_halt = 1'b0;
    logic       rst_out;
    logic       rst_req;

    int n_chk = 0;
    int n_bad = 0;
    int rise_req, rise_out, hi_req, hi_out;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    keyed_wdog #(.CNT_W(CW), .PULSE_LEN(PLEN)) i_keyed_wdog (
        .clk             (clk),
        .rst_n           (rst_n),
        .wr_en           (wr_en),
        .wr_data         (wr_data),
        .cyc_tick        (cyc_tick),
        .idle            (idle),
        .pdown           (pdown),
        .wake_pin        (wake_pin),
        .cfg_rst_out_dis (cfg_rst_out_dis),
        .cfg_idle_halt   (cfg_idle_halt),
        .rst_out         (rst_out),
        .rst_req         (rst_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic key();
        wr(8'h1E);
        wr(8'hE1);
    endtask

    // Runs n ticking cycles; records first high cycle and high counts.
    task automatic run(input int n);
        rise_req = 0; rise_out = 0; hi_req = 0; hi_out = 0;
        cyc_tick = 1'b1;
        for (int i = 1; i <= n; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (rst_req) begin
                hi_req++;
                if (rise_req == 0) rise_req = i;
            end
            if (rst_out) begin
                hi_out++;
                if (rise_out == 0) rise_out = i;
            end
        end
        cyc_tick = 1'b0;
    endtask

    // Watchdog for a hung run.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        @(negedge clk);
        chk("R1 rst_req in reset", int'(rst_req), 0);
        chk("R1 rst_out in reset", int'(rst_out), 0);
        do_reset();
        chk("R1 rst_req after reset", int'(rst_req), 0);
        chk("R1 rst_out after reset", int'(rst_out), 0);

        // R2 / R3: key sequence vectors
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            for (int k = 0; k < int'(VEC[v][7:4]); k++)
                wr(VEC[v][31 - 8*k -: 8]);
            run(MAXC + 5);
            chk($sformatf("R2/R3 vector %0d overflow cycle", v), rise_req,
                VEC[v][0] ? MAXC : 0);
        end

        // R5 / R6 / R9: overflow, pulse length, return to disarmed
        do_reset();
        key();
        run(MAXC + 200);
        chk("R5 overflow cycle", rise_req, MAXC);
        chk("R5 rst_req pulse length", hi_req, PLEN);
        chk("R6 rst_out pulse length", hi_out, PLEN);
        chk("R6 rst_out start", rise_out, MAXC);
        run(MAXC + 10);
        chk("R9 disarmed after pulse", rise_req, 0);

        // R6: masked reset pin
        do_reset();
        cfg_rst_out_dis = 1'b1;
        key();
        run(MAXC + 200);
        chk("R6 masked rst_out", hi_out, 0);
        chk("R6 masked rst_req length", hi_req, PLEN);
        cfg_rst_out_dis = 1'b0;

        // R4: service clears the count
        do_reset();
        key();
        run(600);
        chk("R4 no early overflow", rise_req, 0);
        key();
        run(MAXC + 5);
        chk("R4 serviced overflow cycle", rise_req, MAXC);

        // R4 / R3: broken service and junk writes neither clear nor disarm
        do_reset();
        key();
        run(600);
        wr(8'h1E); wr(8'h00); wr(8'hE1); wr(8'h00); wr(8'hFF);
        run(MAXC);
        chk("R4 junk writes keep count", rise_req, MAXC - 600);

        // R7: idle with halt freezes
        do_reset();
        cfg_idle_halt = 1'b1;
        key();
        run(300);
        idle = 1'b1;
        run(500);
        chk("R7 halted idle no overflow", rise_req, 0);
        idle = 1'b0;
        run(MAXC);
        chk("R7 halted idle resumes", rise_req, MAXC - 300);

        // R7: idle without halt keeps counting
        do_reset();
        cfg_idle_halt = 1'b0;
        key();
        run(300);
        idle = 1'b1;
        run(MAXC);
        chk("R7 idle counts", rise_req, MAXC - 300);
        idle = 1'b0;

        // R8: power-down freeze and wake-pin hold
        do_reset();
        key();
        run(100);
        pdown = 1'b1;
        wake_pin = 1'b0;
        run(200);
        chk("R8 power-down no overflow", rise_req, 0);
        pdown = 1'b0;
        run(300);
        chk("R8 wake pin low holds", rise_req, 0);
        wake_pin = 1'b1;
        run(MAXC);
        chk("R8 count after pin high", rise_req, MAXC - 100);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule